// File: doc/BRIEF.md
# Link Power State Controller

This block keeps track of the power state of one device attached to a serial link port. It works out the link power state that state allows and moves the link there without further help. Software writes the device state. The block checks each write against a capability input and checks the held state against the state reported for the upstream component. It then places the link in the matching low-power state and filters the transactions offered to it. An unsupported write is dropped and flagged. An upstream/downstream pairing that is not allowed raises a level error.

The link partner can ask for idle entry on its own. The block accepts a request for the light standby state (L0s) only when the device is fully on (D0) and the link is active (L0). It refuses every request for the deeper L1 state. When a transaction shows up, the link leaves standby. When the device comes back to D0 from either D3 state, it has lost its functional context, and a flag tells software that full reinitialization is needed.

Device state codes: D0=0, D1=1, D2=2, D3hot=3, D3cold=4. Codes 5 to 7 are invalid. A lower code means more power. Link state codes: L0=0, L0s=1, L1=2, L2/L3 Ready=3, L2/L3=4.

Top module: `lnk_pwr_ctl`

## Requirements
- R1: After reset the device state reads 0 (D0) and the link state reads 0 (L0). hw_ack, hw_nak, wr_err and reinit_req are all 0.
- R2: An accepted write moves the link one cycle later. D1 (1) or D2 (2) gives L1 (2), D3hot (3) gives L2/L3 Ready (3), D3cold (4) gives L2/L3 (4), and D0 (0) gives L0 (0).
- R3: An idle request with hw_req_l1=0 is acknowledged (hw_ack=1 for one cycle, the cycle after the request) and the link moves to L0s (1). This happens only when all of these hold: the device is in D0, the link is in L0, no write is accepted in that cycle, and no transaction strobe is high.
- R4: An idle request with hw_req_l1=1 always gets hw_nak=1 on the next cycle, and the link state does not change.
- R5: An L0s request that does not meet the R3 conditions gets hw_nak=1 on the next cycle. This includes a request while the device is not in D0 and a request while the link is already in L0s.
- R6: In L0s, the cycle after either transaction strobe (mst_req or tgt_req) is high, the link reads L0 (0).
- R7: illegal_combo is high exactly when the upstream state code is greater than the device state code.
- R8: Master transactions are allowed in D0. In D1, D2 and D3hot a master transaction is allowed only if it is a PME message (mst_is_pme=1) and pme_en=1. In D3cold every master transaction is blocked.
- R9: Target transactions are allowed in D0. In D1, D2 and D3hot only configuration targets (tgt_is_cfg=1) are allowed. In D3cold every target transaction is blocked.
- R10: reinit_req is set on an accepted write of D0 made while the device is in D3hot or D3cold. It is not set when returning from D1 or D2. It clears on the next accepted write of a state other than D0.
- R11: A write of code 5 to 7, of D1 while cap_d1=0, or of D2 while cap_d2=0 leaves both the device state and the link state unchanged. It raises wr_err for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe for the device state |
| wr_state | input | 3 | Requested device state code |
| cap_d1 | input | 1 | Device supports D1 |
| cap_d2 | input | 1 | Device supports D2 |
| up_state | input | 3 | Upstream component state code |
| hw_req_vld | input | 1 | Idle-entry request from the link partner |
| hw_req_l1 | input | 1 | Request targets L1 (1) or L0s (0) |
| pme_en | input | 1 | PME messages enabled |
| mst_req | input | 1 | Master transaction strobe |
| mst_is_pme | input | 1 | Master transaction is a PME message |
| tgt_req | input | 1 | Target transaction strobe |
| tgt_is_cfg | input | 1 | Target transaction is a configuration access |
| dev_state | output | 3 | Current device state code |
| link_state | output | 3 | Current link state code |
| hw_ack | output | 1 | Idle request accepted (one cycle) |
| hw_nak | output | 1 | Idle request refused (one cycle) |
| mst_allow | output | 1 | Master transaction passes |
| mst_block | output | 1 | Master transaction is blocked |
| tgt_allow | output | 1 | Target transaction passes |
| tgt_block | output | 1 | Target transaction is blocked |
| illegal_combo | output | 1 | Upstream/downstream state pairing not allowed |
| wr_err | output | 1 | Unsupported write dropped (one cycle) |
| reinit_req | output | 1 | Full reinitialization needed after D3 |

## Verification
Every device state is written in turn, and the link state is read after each write. This separates the D1/D2 mapping from the two D3 mappings and shows that the reinit flag follows D3 exits but not D1/D2 exits. Idle requests are sent in several situations:
- in D0 with the link in L0;
- with the link already in L0s;
- in a low-power device state;
- with the L1 target;
- in the same cycle as a pending transaction.

Between them, these show whether acknowledgement depends on the device state, on the link state, on the requested target and on traffic. Master and target strobes are tried with the PME, PME-enable and configuration qualifiers set both ways, in D0, D1 and D3cold. This separates the three filter regimes. Writes of unsupported states, with the capability inputs cleared, show that nothing changes and that the error lasts one cycle.

// File: rtl/lnk_pwr_ctl.sv
module lnk_pwr_ctl #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_state,
  input  logic          cap_d1,
  input  logic          cap_d2,
  input  logic [SW-1:0] up_state,
  input  logic          hw_req_vld,
  input  logic          hw_req_l1,
  input  logic          pme_en,
  input  logic          mst_req,
  input  logic          mst_is_pme,
  input  logic          tgt_req,
  input  logic          tgt_is_cfg,
  output logic [SW-1:0] dev_state,
  output logic [SW-1:0] link_state,
  output logic          hw_ack,
  output logic          hw_nak,
  output logic          mst_allow,
  output logic          mst_block,
  output logic          tgt_allow,
  output logic          tgt_block,
  output logic          illegal_combo,
  output logic          wr_err,
  output logic          reinit_req
);
  localparam logic [SW-1:0] DS_ON   = SW'(0);
  localparam logic [SW-1:0] DS_LT   = SW'(1);
  localparam logic [SW-1:0] DS_DEEP = SW'(2);
  localparam logic [SW-1:0] DS_HOT  = SW'(3);
  localparam logic [SW-1:0] DS_OFF  = SW'(4);
  localparam logic [SW-1:0] LK_ACT  = SW'(0);
  localparam logic [SW-1:0] LK_SBY  = SW'(1);
  localparam logic [SW-1:0] LK_SLP  = SW'(2);
  localparam logic [SW-1:0] LK_RDY  = SW'(3);
  localparam logic [SW-1:0] LK_DWN  = SW'(4);

  logic          wr_ok, wr_acc, pending, grant, low_pwr;
  logic [SW-1:0] link_nxt;

  assign wr_ok = (wr_state <= DS_OFF) &&
                 !(wr_state == DS_LT && !cap_d1) &&
                 !(wr_state == DS_DEEP && !cap_d2);
  assign wr_acc  = wr_en && wr_ok;
  assign pending = mst_req || tgt_req;
  assign grant   = hw_req_vld && !hw_req_l1 && dev_state == DS_ON &&
                   link_state == LK_ACT && !wr_acc && !pending;

  always_comb begin
    case (wr_state)
      DS_ON:          link_nxt = LK_ACT;
      DS_LT, DS_DEEP: link_nxt = LK_SLP;
      DS_HOT:         link_nxt = LK_RDY;
      default:        link_nxt = LK_DWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_state  <= DS_ON;
      link_state <= LK_ACT;
      hw_ack     <= 1'b0;
      hw_nak     <= 1'b0;
      wr_err     <= 1'b0;
      reinit_req <= 1'b0;
    end else begin
      hw_ack <= grant;
      hw_nak <= hw_req_vld && !grant;
      wr_err <= wr_en && !wr_ok;
      if (wr_acc) begin
        dev_state  <= wr_state;
        link_state <= link_nxt;
        if (wr_state != DS_ON)
          reinit_req <= 1'b0;
        else if (dev_state >= DS_HOT)
          reinit_req <= 1'b1;
      end else if (link_state == LK_SBY && pending) begin
        link_state <= LK_ACT;
      end else if (grant) begin
        link_state <= LK_SBY;
      end
    end
  end

  assign low_pwr       = dev_state != DS_ON && dev_state != DS_OFF;
  assign illegal_combo = up_state > dev_state;

  assign mst_allow = mst_req && ((dev_state == DS_ON) ||
                                 (low_pwr && mst_is_pme && pme_en));
  assign mst_block = mst_req && !mst_allow;
  assign tgt_allow = tgt_req && ((dev_state == DS_ON) || (low_pwr && tgt_is_cfg));
  assign tgt_block = tgt_req && !tgt_allow;

  // R4
  l1_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req_vld && hw_req_l1) |=> (hw_nak && !hw_ack));

  // R5
  not_on_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req_vld && dev_state != DS_ON) |=> hw_nak);

  // R2
  light_sleep_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == DS_LT || dev_state == DS_DEEP) |-> link_state == LK_SLP);

  // R3
  standby_only_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == LK_SBY) |-> dev_state == DS_ON);

  // R8
  master_lowpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state != DS_ON && mst_allow) |-> (mst_is_pme && pme_en && dev_state != DS_OFF));

  // R10
  reinit_after_d3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_state) >= DS_HOT && dev_state == DS_ON) |-> reinit_req);

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $stable(dev_state));
endmodule

// File: tb/lnk_pwr_ctl_bench.sv
module lnk_pwr_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, cap_d1 = 1, cap_d2 = 1, hw_req_vld = 0, hw_req_l1 = 0;
  logic pme_en = 0, mst_req = 0, mst_is_pme = 0, tgt_req = 0, tgt_is_cfg = 0;
  logic [2:0] wr_state = 0, up_state = 0, dev_state, link_state;
  logic hw_ack, hw_nak, mst_allow, mst_block, tgt_allow, tgt_block;
  logic illegal_combo, wr_err, reinit_req;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lnk_pwr_ctl u_lnk_pwr_ctl (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_dev(int code);
    wr_en = 1; wr_state = 3'(code);
    tick();
    wr_en = 0;
  endtask

  task automatic hw_req(bit to_l1);
    hw_req_vld = 1; hw_req_l1 = to_l1;
    tick();
    hw_req_vld = 0; hw_req_l1 = 0;
  endtask

  task automatic t_reset();
    chk("R1 dev", dev_state, 0);
    chk("R1 link", link_state, 0);
    chk("R1 flags", {hw_ack, hw_nak, wr_err, reinit_req}, 0);
  endtask

  task automatic t_links();
    write_dev(1); chk("R2 D1 link", link_state, 2); chk("R2 D1 dev", dev_state, 1);
    write_dev(2); chk("R2 D2 link", link_state, 2);
    write_dev(3); chk("R2 D3hot link", link_state, 3);
    write_dev(4); chk("R2 D3cold link", link_state, 4);
    write_dev(0); chk("R2 D0 link", link_state, 0);
    chk("R10 reinit after D3cold", reinit_req, 1);
    write_dev(1); chk("R10 reinit cleared", reinit_req, 0);
    write_dev(0); chk("R10 no reinit from D1", reinit_req, 0);
    write_dev(3); write_dev(0); chk("R10 reinit after D3hot", reinit_req, 1);
  endtask

  task automatic t_idle();
    hw_req(0);
    chk("R3 ack", hw_ack, 1); chk("R3 no nak", hw_nak, 0); chk("R3 link L0s", link_state, 1);
    hw_req(0);
    chk("R5 nak in L0s", hw_nak, 1); chk("R5 no ack in L0s", hw_ack, 0);
    tgt_req = 1; tick(); tgt_req = 0;
    chk("R6 exit L0s", link_state, 0);
    hw_req(1);
    chk("R4 L1 nak", hw_nak, 1); chk("R4 link stays", link_state, 0);
    hw_req_vld = 1; mst_req = 1; tick(); hw_req_vld = 0; mst_req = 0;
    chk("R3 nak with pending", hw_nak, 1); chk("R3 link L0 with pending", link_state, 0);
    write_dev(2);
    hw_req(0);
    chk("R5 nak in D2", hw_nak, 1); chk("R5 link D2", link_state, 2);
    write_dev(0);
  endtask

  task automatic t_filter();
    mst_req = 1; tgt_req = 1; #1;
    chk("R8 D0 master", mst_allow, 1); chk("R9 D0 target", tgt_allow, 1);
    mst_req = 0; tgt_req = 0;
    write_dev(1);
    mst_req = 1; mst_is_pme = 1; pme_en = 0; #1;
    chk("R8 pme disabled", mst_block, 1);
    pme_en = 1; #1;
    chk("R8 pme enabled", mst_allow, 1);
    mst_is_pme = 0; #1;
    chk("R8 non-pme blocked", mst_block, 1);
    mst_req = 0; tgt_req = 1; tgt_is_cfg = 1; #1;
    chk("R9 cfg allowed", tgt_allow, 1);
    tgt_is_cfg = 0; #1;
    chk("R9 mem blocked", tgt_block, 1);
    tgt_req = 0;
    write_dev(4);
    mst_req = 1; mst_is_pme = 1; tgt_req = 1; tgt_is_cfg = 1; #1;
    chk("R8 D3cold master", mst_block, 1); chk("R9 D3cold target", tgt_block, 1);
    mst_req = 0; mst_is_pme = 0; tgt_req = 0; tgt_is_cfg = 0; pme_en = 0;
    write_dev(0);
  endtask

  task automatic t_illegal();
    up_state = 1; #1; chk("R7 D0 up D1", illegal_combo, 1);
    up_state = 0; write_dev(2);
    up_state = 2; #1; chk("R7 D2 up D2", illegal_combo, 0);
    up_state = 3; #1; chk("R7 D2 up D3hot", illegal_combo, 1);
    write_dev(4);
    up_state = 4; #1; chk("R7 D3cold up D3cold", illegal_combo, 0);
    up_state = 0; write_dev(0);
  endtask

  task automatic t_unsup();
    cap_d1 = 0; write_dev(1);
    chk("R11 err D1", wr_err, 1); chk("R11 dev kept", dev_state, 0); chk("R11 link kept", link_state, 0);
    tick(); chk("R11 err one cycle", wr_err, 0);
    write_dev(6); chk("R11 err code6", wr_err, 1); chk("R11 dev kept code6", dev_state, 0);
    cap_d2 = 0; write_dev(2); chk("R11 err D2", wr_err, 1); chk("R11 link kept D2", link_state, 0);
    cap_d1 = 1; cap_d2 = 1;
    write_dev(1); chk("R11 supported ok", wr_err, 0); chk("R11 supported dev", dev_state, 1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    t_reset();
    t_links();
    t_idle();
    t_filter();
    t_illegal();
    t_unsup();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule